// File: doc/BRIEF.md
# Atomic Multibyte Register Bank

This block is a byte-wide host register file. The registers behind it are one, two or four bytes wide. A host reaches every register through an 8-bit address, a byte of write data, a byte of registered read data, and single-cycle read and write strobes. Registers wider than one byte go through holding registers. A read sees a coherent snapshot of the whole value, and a write lands as one atomic update even when the host spaces the byte accesses far apart.

Reading the lowest byte of a wide register freezes that register's upper bytes. Later reads of the upper bytes return the frozen copy, whatever the live value does in the meantime. Writing a wide register works as follows. The host writes the lowest byte first, then each higher byte in rising order. The bytes collect in a staging register, and the target changes only on the edge that takes the top byte. The bank contains:
- fixed identification bytes;
- a one-byte scratch register;
- two-byte and four-byte read/write registers;
- a two-byte live status input;
- a four-byte free-running cycle counter;
- a two-byte interrupt event register. Event pulses set its bits, and writing a one to a bit clears it.

Top module: `amb_regbank`

## Requirements
- R1: A one-byte register is written on the edge that takes its write strobe. The read strobe returns the addressed byte on `rdata_o` one cycle later. `rdata_o` holds its value while no read strobe is present.
- R2: A read of byte 0 of a wide register returns the live byte 0. On the same edge, the read copies every higher byte of that register into the read holding register.
- R3: A read of byte k>0 returns byte k of the held copy. The upper bytes can be read in any order and at any later time, and live changes do not alter them.
- R4: A wide write collects bytes in rising order starting at byte 0. The target keeps its old value until the top byte is written, and then takes all of its bytes on that edge.
- R5: A write to byte k>0 is ignored unless bytes 0 through k-1 of the same register were the latest staged writes. A new byte-0 write discards any partly staged value.
- R6: The event register sits at 0x5E (bits 7:0) and 0x5F (bits 15:8). A one-cycle pulse on `evt_i[b]` sets bit b. The write-one-to-clear mask is staged like any wide write, and the clear applies to both bytes when 0x5F is written. If a set and a clear hit the same bit on the same edge, the set wins.
- R7: `irq_o` is the OR of all event bits. It rises on the same edge that sets the first bit.
- R8: The identification bytes read 0x30 at 0x00 and 0x41 at 0x01. Both 0x02 and 0x03 read 0x01.
- R9: Addresses 0x40 to 0x43 hold a 32-bit counter, byte 0 lowest. It increments once every cycle out of reset.
- R10: A read of an unmapped address returns 0x00. A write to an unmapped address, or to a read-only register (identification, status at 0x30 to 0x31, counter), changes nothing.
- R11: Synchronous active-high reset clears the read and write holding registers, all read/write registers, the counter, the event bits, `rdata_o` and `irq_o`.
- R12: Map of the read/write registers: the scratch byte is at 0x10. The two-byte register is at 0x20 to 0x21 and the four-byte register at 0x24 to 0x27, byte 0 at the lowest address. The status input `stat_i` is read at 0x30 (bits 7:0) and 0x31 (bits 15:8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Registered read data |
| stat_i | input | 16 | Live status value |
| evt_i | input | 16 | Event pulses, one per interrupt bit |
| irq_o | output | 1 | OR of the event bits |

## Verification
A read result sits on `rdata_o` one edge after its strobe. A write, commit or clear shows in the next read and not earlier. An event pulse reaches `irq_o` on the same edge that takes it. The bench drives each strobe for exactly one clock, between two falling edges, and samples at the second falling edge. Every expectation therefore refers to one known rising edge. The counter checks compare the difference of two snapshots with the number of edges the bench counted between the two byte-0 reads. This holds no matter how much time passes between the byte reads.

// File: rtl/amb_pkg.sv
package amb_pkg;
  localparam int NREG = 9;
  localparam int MAXB = 4;
  localparam int IW   = $clog2(MAXB);
  localparam int RIDW = $clog2(NREG);

  localparam int R_ID = 0, R_REV = 1, R_SUB = 2, R_SCR = 3, R_CFG = 4,
                 R_LIM = 5, R_STAT = 6, R_CNT = 7, R_EVT = 8;

  localparam logic [15:0] CHIP_ID  = 16'h4130;
  localparam logic [7:0]  REV_VAL  = 8'h01;
  localparam logic [7:0]  SUB_VAL  = 8'h01;

  typedef enum logic [1:0] {K_RO, K_RW, K_W1C} kind_e;

  typedef struct packed {
    logic            hit;
    logic [RIDW-1:0] rid;
    logic [IW-1:0]   idx;
    logic [IW-1:0]   last;
    logic            wable;
  } dec_t;

  function automatic logic [7:0] reg_base(int i);
    case (i)
      R_ID:   return 8'h00;
      R_REV:  return 8'h02;
      R_SUB:  return 8'h03;
      R_SCR:  return 8'h10;
      R_CFG:  return 8'h20;
      R_LIM:  return 8'h24;
      R_STAT: return 8'h30;
      R_CNT:  return 8'h40;
      default: return 8'h5E;
    endcase
  endfunction

  function automatic int reg_bytes(int i);
    case (i)
      R_REV, R_SUB, R_SCR: return 1;
      R_LIM, R_CNT:        return 4;
      default:             return 2;
    endcase
  endfunction

  function automatic kind_e reg_kind(int i);
    case (i)
      R_SCR, R_CFG, R_LIM: return K_RW;
      R_EVT:               return K_W1C;
      default:             return K_RO;
    endcase
  endfunction
endpackage

// File: rtl/amb_decode.sv
module amb_decode
  import amb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  logic [NREG-1:0] match;
  logic [AW-1:0]   off [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign off[g]   = addr_i - AW'(reg_base(g));
    assign match[g] = (addr_i >= AW'(reg_base(g))) && (off[g] < AW'(reg_bytes(g)));
  end

  always_comb begin
    dec_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (match[i]) begin
        dec_o.hit   = 1'b1;
        dec_o.rid   = RIDW'(i);
        dec_o.idx   = off[i][IW-1:0];
        dec_o.last  = IW'(reg_bytes(i) - 1);
        dec_o.wable = (reg_kind(i) != K_RO);
      end
    end
  end
endmodule

// File: rtl/amb_rdsnap.sv
module amb_rdsnap #(
  parameter  int DW = 8,
  parameter  int NB = 4,
  localparam int IW = $clog2(NB),
  localparam int HW = DW * (NB - 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_i,
  input  logic           hit_i,
  input  logic [IW-1:0]  idx_i,
  input  logic [IW-1:0]  last_i,
  input  logic [DW*NB-1:0] live_i,
  output logic [DW-1:0]  rdata_o
);
  logic [HW-1:0] hold_q;
  logic [DW-1:0] hold_sel;

  always_comb begin
    hold_sel = '0;
    for (int b = 1; b < NB; b++)
      if (idx_i == IW'(b)) hold_sel = hold_q[DW*(b-1) +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      hold_q  <= '0;
    end else if (rd_i) begin
      if (!hit_i) begin
        rdata_o <= '0;
      end else if (idx_i == '0) begin
        rdata_o <= live_i[DW-1:0];
        if (last_i != '0) hold_q <= live_i[DW*NB-1:DW];
      end else begin
        rdata_o <= hold_sel;
      end
    end
  end
endmodule

// File: rtl/amb_wstage.sv
module amb_wstage #(
  parameter  int DW   = 8,
  parameter  int NB   = 4,
  parameter  int RIDW = 4,
  localparam int IW   = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             hit_i,
  input  logic             wable_i,
  input  logic [RIDW-1:0]  rid_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [IW-1:0]    last_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             commit_o,
  output logic [RIDW-1:0]  crid_o,
  output logic [DW*NB-1:0] cval_o
);
  logic [DW*NB-1:0] stg_q;
  logic [RIDW-1:0]  sid_q;
  logic [IW-1:0]    nxt_q;
  logic             act_q;
  logic             wok, first, cont;

  assign wok   = wr_i && hit_i && wable_i;
  assign first = wok && (idx_i == '0);
  assign cont  = wok && (idx_i != '0) && act_q && (sid_q == rid_i) && (nxt_q == idx_i);

  always_comb begin
    commit_o = (first && last_i == '0) || (cont && idx_i == last_i);
    crid_o   = rid_i;
    cval_o   = first ? '0 : stg_q;
    for (int b = 0; b < NB; b++)
      if (idx_i == IW'(b)) cval_o[DW*b +: DW] = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
      sid_q <= '0;
      nxt_q <= '0;
      act_q <= 1'b0;
    end else if (first && last_i != '0) begin
      stg_q <= cval_o;
      sid_q <= rid_i;
      nxt_q <= IW'(1);
      act_q <= 1'b1;
    end else if (cont) begin
      if (idx_i == last_i) begin
        act_q <= 1'b0;
      end else begin
        stg_q <= cval_o;
        nxt_q <= nxt_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/amb_evt.sv
module amb_evt #(
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] evt_i,
  input  logic          clr_i,
  input  logic [EW-1:0] mask_i,
  output logic [EW-1:0] ev_o,
  output logic          irq_o
);
  logic [EW-1:0] ev_nxt;

  assign ev_nxt = (ev_o & ~(clr_i ? mask_i : '0)) | evt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_o  <= '0;
      irq_o <= 1'b0;
    end else begin
      ev_o  <= ev_nxt;
      irq_o <= |ev_nxt;
    end
  end
endmodule

// File: rtl/amb_regbank.sv
module amb_regbank
  import amb_pkg::*;
#(
  parameter  int AW = 8,
  parameter  int DW = 8,
  localparam int SW = DW * reg_bytes(R_STAT),
  localparam int EW = DW * reg_bytes(R_EVT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic [SW-1:0] stat_i,
  input  logic [EW-1:0] evt_i,
  output logic          irq_o
);
  localparam int LW   = DW * MAXB;
  localparam int CFGW = DW * reg_bytes(R_CFG);
  localparam int LIMW = DW * reg_bytes(R_LIM);
  localparam int CW   = DW * reg_bytes(R_CNT);

  dec_t            dec;
  logic [LW-1:0]   live;
  logic            commit;
  logic [RIDW-1:0] crid;
  logic [LW-1:0]   cval;
  logic [EW-1:0]   ev_w;
  logic [DW-1:0]   scr_q;
  logic [CFGW-1:0] cfg_q;
  logic [LIMW-1:0] lim_q;
  logic [CW-1:0]   cnt_q;

  amb_decode #(.AW(AW)) u_dec (.addr_i(addr_i), .dec_o(dec));

  always_comb begin
    case (dec.rid)
      RIDW'(R_ID):   live = LW'(CHIP_ID);
      RIDW'(R_REV):  live = LW'(REV_VAL);
      RIDW'(R_SUB):  live = LW'(SUB_VAL);
      RIDW'(R_SCR):  live = LW'(scr_q);
      RIDW'(R_CFG):  live = LW'(cfg_q);
      RIDW'(R_LIM):  live = LW'(lim_q);
      RIDW'(R_STAT): live = LW'(stat_i);
      RIDW'(R_CNT):  live = LW'(cnt_q);
      RIDW'(R_EVT):  live = LW'(ev_w);
      default:       live = '0;
    endcase
  end

  amb_rdsnap #(.DW(DW), .NB(MAXB)) u_rd (
    .clk(clk), .rst(rst), .rd_i(rd_i), .hit_i(dec.hit),
    .idx_i(dec.idx), .last_i(dec.last), .live_i(live), .rdata_o(rdata_o)
  );

  amb_wstage #(.DW(DW), .NB(MAXB), .RIDW(RIDW)) u_wr (
    .clk(clk), .rst(rst), .wr_i(wr_i), .hit_i(dec.hit), .wable_i(dec.wable),
    .rid_i(dec.rid), .idx_i(dec.idx), .last_i(dec.last), .wdata_i(wdata_i),
    .commit_o(commit), .crid_o(crid), .cval_o(cval)
  );

  amb_evt #(.EW(EW)) u_evt (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .clr_i(commit && crid == RIDW'(R_EVT)), .mask_i(cval[EW-1:0]),
    .ev_o(ev_w), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_q <= '0;
      cfg_q <= '0;
      lim_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (commit && crid == RIDW'(R_SCR)) scr_q <= cval[DW-1:0];
      if (commit && crid == RIDW'(R_CFG)) cfg_q <= cval[CFGW-1:0];
      if (commit && crid == RIDW'(R_LIM)) lim_q <= cval[LIMW-1:0];
    end
  end
endmodule

// File: rtl/amb_regbank_chk.sv
module amb_regbank_chk #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int EW   = 16,
  parameter int CFGW = 16,
  parameter int CW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_i,
  input logic            wr_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   rdata_o,
  input logic            irq_o,
  input logic [EW-1:0]   evt_i,
  input logic            hit,
  input logic [EW-1:0]   ev,
  input logic [CFGW-1:0] cfg,
  input logic [CW-1:0]   cnt
);
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_i |=> $stable(rdata_o)); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_i && !hit) |=> rdata_o == '0); // R10
  AST_ID_LOW_BYTE: assert property (@(posedge clk) disable iff (rst) (rd_i && addr_i == '0) |=> rdata_o == DW'(8'h30)); // R8
  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (rst) (wr_i && addr_i == AW'(8'h20)) |=> $stable(cfg)); // R4
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst) (|evt_i) |=> irq_o); // R6
  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst) irq_o == (|ev)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> cnt == $past(cnt) + CW'(1)); // R9
endmodule

bind amb_regbank amb_regbank_chk #(
  .AW(AW), .DW(DW), .EW(EW), .CFGW(CFGW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .evt_i(evt_i), .hit(dec.hit),
  .ev(ev_w), .cfg(cfg_q), .cnt(cnt_q)
);

// File: tb/amb_regbank_test.sv
`timescale 1ns/1ps
module amb_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [15:0] stat_i = '0;
  logic [15:0] evt_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  amb_regbank uut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .stat_i(stat_i), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
    last_cyc = cyc;
  endtask

  task automatic rdn(input logic [7:0] a, input int nb, input int gap,
                     output logic [31:0] v, output int c);
    logic [7:0] b;
    v = '0;
    rd(a, b); v[7:0] = b; c = last_cyc;
    repeat (gap) @(negedge clk);
    for (int k = 1; k < nb; k++) begin
      rd(a + 8'(k), b);
      v[8*k +: 8] = b;
    end
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  function automatic bit mapped(input int a);
    return (a <= 3) || (a == 'h10) || (a >= 'h20 && a <= 'h21) ||
           (a >= 'h24 && a <= 'h27) || (a >= 'h30 && a <= 'h31) ||
           (a >= 'h40 && a <= 'h43) || (a >= 'h5E && a <= 'h5F);
  endfunction

  task automatic finish_sim;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v1, v2;
    int c1, c2;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 rdata", 32'(rdata_o), 0);
    chk("R11 irq", 32'(irq_o), 0);
    rd(8'h01, b); chk("R11 hold clear", 32'(b), 0);
    rdn(8'h24, 4, 0, v1, c1); chk("R11 R12 lim reset", v1, 0);
    rdn(8'h5E, 2, 0, v1, c1); chk("R11 evt reset", v1, 0);

    // R8 identification
    rd(8'h00, b); chk("R8 id lo", 32'(b), 32'h30);
    rd(8'h01, b); chk("R8 id hi", 32'(b), 32'h41);
    rd(8'h02, b); chk("R8 rev", 32'(b), 32'h01);
    rd(8'h03, b); chk("R8 subrev", 32'(b), 32'h01);

    // R1 scratch sweep
    for (int d = 0; d < 256; d++) begin
      wr(8'h10, 8'(d));
      rd(8'h10, b);
      chk("R1 scratch", 32'(b), 32'(d));
      @(negedge clk);
      chk("R1 hold rdata", 32'(rdata_o), 32'(d));
    end

    // R4 staged 2-byte write
    wr(8'h20, 8'h11);
    rdn(8'h20, 2, 0, v1, c1); chk("R4 before commit", v1, 0);
    wr(8'h21, 8'h22);
    rdn(8'h20, 2, 0, v1, c1); chk("R4 R12 cfg commit", v1, 32'h2211);

    // R5 out-of-order and restart
    wr(8'h21, 8'h99);
    rdn(8'h20, 2, 0, v1, c1); chk("R5 lone msb ignored", v1, 32'h2211);
    wr(8'h24, 8'hA1); wr(8'h25, 8'hB2);
    wr(8'h24, 8'hC3);
    wr(8'h26, 8'h77);
    wr(8'h25, 8'hD4); wr(8'h26, 8'hE5);
    rdn(8'h24, 4, 0, v1, c1); chk("R4 lim not yet", v1, 0);
    wr(8'h27, 8'hF6);
    rdn(8'h24, 4, 0, v1, c1); chk("R5 restart commit", v1, 32'hF6E5D4C3);

    // R3 any order
    rd(8'h24, b);
    rd(8'h27, b); chk("R3 order b3", 32'(b), 32'hF6);
    rd(8'h25, b); chk("R3 order b1", 32'(b), 32'hD4);
    rd(8'h26, b); chk("R3 order b2", 32'(b), 32'hE5);

    // R2 R3 live status snapshot
    stat_i = 16'h1234;
    rd(8'h30, b); chk("R2 stat lo", 32'(b), 32'h34);
    stat_i = 16'hABCD;
    rd(8'h31, b); chk("R3 stat frozen", 32'(b), 32'h12);
    rd(8'h30, b); chk("R2 stat lo new", 32'(b), 32'hCD);
    rd(8'h31, b); chk("R3 stat hi new", 32'(b), 32'hAB);

    // R9 counter with frozen upper bytes across a long gap
    rdn(8'h40, 4, 700, v1, c1);
    rdn(8'h40, 4, 0, v2, c2);
    chk("R9 R3 counter delta", v2 - v1, 32'(c2 - c1));
    chk("R9 counter nonzero", 32'(v1 != 0), 1);

    // R10 unmapped sweep and read-only writes
    for (int a = 0; a < 256; a++) begin
      if (!mapped(a)) begin
        wr(8'(a), 8'hFF);
        rd(8'(a), b);
        chk("R10 unmapped read", 32'(b), 0);
      end
    end
    wr(8'h02, 8'h55); wr(8'h00, 8'h00); wr(8'h01, 8'h00);
    rd(8'h02, b); chk("R10 ro rev", 32'(b), 32'h01);
    rd(8'h00, b); chk("R10 ro id", 32'(b), 32'h30);
    wr(8'h40, 8'h00); wr(8'h41, 8'h00); wr(8'h42, 8'h00); wr(8'h43, 8'h00);
    rdn(8'h40, 4, 0, v1, c1); chk("R10 ro counter", 32'(v1 > 32'd2000), 1);
    rd(8'h10, b); chk("R10 scratch kept", 32'(b), 32'hFF);
    rdn(8'h20, 2, 0, v1, c1); chk("R10 cfg kept", v1, 32'h2211);
    rdn(8'h24, 4, 0, v1, c1); chk("R10 lim kept", v1, 32'hF6E5D4C3);

    // R6 R7 per-bit sweep
    for (int k = 0; k < 16; k++) begin
      pulse(16'(1) << k);
      chk("R7 irq set", 32'(irq_o), 1);
      rdn(8'h5E, 2, 0, v1, c1); chk("R6 bit set", v1, 32'(1) << k);
      wr(8'h5E, 8'(16'(1) << k)); wr(8'h5F, 8'((16'(1) << k) >> 8));
      rdn(8'h5E, 2, 0, v1, c1); chk("R6 bit clear", v1, 0);
      chk("R7 irq clear", 32'(irq_o), 0);
    end

    // R6 partial mask staged until msb
    pulse(16'h8003);
    wr(8'h5E, 8'h01);
    rdn(8'h5E, 2, 0, v1, c1); chk("R6 clear waits msb", v1, 32'h8003);
    wr(8'h5F, 8'h00);
    rdn(8'h5E, 2, 0, v1, c1); chk("R6 clear bit0", v1, 32'h8002);

    // R6 set wins over clear on the same edge
    wr(8'h5E, 8'h02);
    @(negedge clk);
    wr_i = 1'b1; addr_i = 8'h5F; wdata_i = 8'h80; evt_i = 16'h0002;
    @(negedge clk);
    wr_i = 1'b0; evt_i = '0;
    rdn(8'h5E, 2, 0, v1, c1); chk("R6 set wins", v1, 32'h0002);
    chk("R7 irq still set", 32'(irq_o), 1);
    wr(8'h5E, 8'hFF); wr(8'h5F, 8'hFF);
    @(negedge clk);
    chk("R7 irq low", 32'(irq_o), 0);

    finish_sim();
  end
endmodule